// File: doc/BRIEF.md
# Line Memory Sequencer with Automatic Self-Refresh

This block keeps a full frame of display lines, 200 rows of 80 bits each, and walks through them once per line pulse. Each time the line pulse input falls, the row at the current row position is copied into an 80-bit output latch. The line presented on the parallel input is captured into a write register. One cycle later that register is stored into the same row, and the row position then moves on. The latch therefore always shows what the row held before this line's update.

The block decides on its own whether a line period carries new data. If the shift clock input showed at least one rising edge since the previous line event, the event writes back as described above. If the shift clock stayed idle, the event is a self-refresh event. The row is still read out and the row position still advances, but the memory is left untouched. A frame-start input that is high at a line event forces that event to use row 0. All inputs are sampled on one system clock, and their edges are detected synchronously.

Top module: `line_refresh_mem`

## Requirements
- R1: After reset, `latchOut` is 0, `refreshMode` is 0, every memory row holds 0 and the row position is 0.
- R2: A line event is a clock edge at which `lineP` is sampled low after having been sampled high at the previous edge. One cycle after that edge, `latchOut` holds the row selected for the event.
- R3: Within one event the read happens before the write, so `latchOut` shows the row's contents from before this event's write.
- R4: In a normal event, the `lineData` value sampled at the event edge is written into the selected row on the next clock edge.
- R5: After each event the row position becomes the selected row plus one, and wraps from 199 to 0.
- R6: If no rising edge of `shiftClk` was sampled since the previous event (or since reset), the event is a self-refresh event. The row is read and the row position advances, but no write takes place, and `refreshMode` reads 1 from one cycle after the event.
- R7: A single rising edge of `shiftClk` anywhere in the line period makes the next event a normal write event, with `refreshMode` 0.
- R8: If `frameStart` is high at the event edge, row 0 is read and written, and the following event uses row 1.
- R9: Between events, `latchOut` and `refreshMode` hold their values, whatever `shiftClk` and `lineData` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineP | input | 1 | Line pulse; its falling edge starts a line event |
| shiftClk | input | 1 | Shift clock; any rising edge marks the line as carrying data |
| frameStart | input | 1 | Frame start; high at a line event selects row 0 |
| lineData | input | 80 | Parallel line to be written back at the next normal event |
| latchOut | output | 80 | Row read out at the latest line event |
| refreshMode | output | 1 | 1 when the latest event was a self-refresh event |

## Verification
A wrong row position or a missed write shows up on `latchOut` only when that row is next read out. That can be up to a full frame of 200 line events later. The bench therefore runs one complete written frame followed by a full self-refresh frame, and compares every row read against a reference model. A wrong self-refresh decision shows at `refreshMode` one cycle after the event itself. It shows on `latchOut` once the row comes round again with data that should or should not have been replaced.

// File: rtl/line_refresh_pkg.sv
package line_refresh_pkg;
  localparam int LINE_W = 80;
  localparam int DEPTH  = 200;
  localparam int ROW_W  = $clog2(DEPTH);

  typedef logic [ROW_W-1:0] row_t;

  typedef struct packed {
    logic capture;   // read row into latch, load write register
    row_t readRow;   // row used by the capture
    logic commit;    // second phase of the event
    logic writeEn;   // commit stores the write register
    row_t writeRow;  // row stored at commit
  } strobes_t;
endpackage

// File: rtl/line_refresh_ctrl.sv
module line_refresh_ctrl
  import line_refresh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineP,
  input  logic     shiftClk,
  input  logic     frameStart,
  output strobes_t st,
  output logic     refreshMode
);
  logic lpPrev, sclPrev, sawClk, commitPend, writeEn;
  row_t rowIdx, rowHold, readRow, nextRow;
  logic lpFall, sclRise, hasData;

  assign lpFall  = lpPrev & ~lineP;
  assign sclRise = ~sclPrev & shiftClk;
  assign hasData = sawClk | sclRise;
  assign readRow = frameStart ? '0 : rowIdx;
  assign nextRow = (rowHold == row_t'(DEPTH - 1)) ? '0 : rowHold + row_t'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpPrev      <= 1'b0;
      sclPrev     <= 1'b0;
      sawClk      <= 1'b0;
      commitPend  <= 1'b0;
      writeEn     <= 1'b0;
      refreshMode <= 1'b0;
      rowIdx      <= '0;
      rowHold     <= '0;
    end else begin
      lpPrev  <= lineP;
      sclPrev <= shiftClk;
      if (lpFall) begin
        sawClk      <= 1'b0;
        writeEn     <= hasData;
        refreshMode <= ~hasData;
        rowHold     <= readRow;
        commitPend  <= 1'b1;
      end else begin
        if (sclRise) sawClk <= 1'b1;
        commitPend <= 1'b0;
      end
      if (commitPend) rowIdx <= nextRow;
    end
  end

  always_comb begin
    st.capture  = lpFall;
    st.readRow  = readRow;
    st.commit   = commitPend;
    st.writeEn  = writeEn;
    st.writeRow = rowHold;
  end

  // R5: row position never leaves the memory range
  assert_row_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    rowIdx < row_t'(DEPTH));

  // R4: every event is followed by its commit phase
  assert_commit_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    lpFall |=> commitPend);

  // R5: after commit the position is the held row plus one, or wrapped to 0
  assert_row_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    commitPend |=> (rowIdx == '0 || rowIdx == $past(rowHold) + row_t'(1)));

  // R8: frame start forces row 0 for the event
  assert_frame_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lpFall && frameStart) |=> rowHold == '0);

  // R9: mode flag changes only through an event
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lpFall |=> $stable(refreshMode));
endmodule

// File: rtl/line_refresh_dp.sv
module line_refresh_dp
  import line_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [LINE_W-1:0] lineData,
  output logic [LINE_W-1:0] latchOut
);
  logic [LINE_W-1:0] mem [DEPTH];
  logic [LINE_W-1:0] wrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wrReg    <= '0;
      latchOut <= '0;
    end else begin
      if (st.capture) begin
        latchOut <= mem[st.readRow];
        wrReg    <= lineData;
      end
      if (st.commit && st.writeEn) mem[st.writeRow] <= wrReg;
    end
  end

  // R9: latch changes only on an event
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> $stable(latchOut));

  // R6: a self-refresh commit leaves the row unchanged
  assert_refresh_nowrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && !st.writeEn) |=> mem[$past(st.writeRow)] == $past(mem[st.writeRow]));
endmodule

// File: rtl/line_refresh_mem.sv
module line_refresh_mem
  import line_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineP,
  input  logic              shiftClk,
  input  logic              frameStart,
  input  logic [LINE_W-1:0] lineData,
  output logic [LINE_W-1:0] latchOut,
  output logic              refreshMode
);
  strobes_t st;

  line_refresh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineP(lineP), .shiftClk(shiftClk),
    .frameStart(frameStart), .st(st), .refreshMode(refreshMode)
  );

  line_refresh_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .lineData(lineData), .latchOut(latchOut)
  );
endmodule

// File: tb/sim_line_refresh_mem.sv
module sim_line_refresh_mem;
  localparam int W = 80;
  localparam int D = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineP = 1'b0, shiftClk = 1'b0, frameStart = 1'b0;
  logic [W-1:0] lineData = '0;
  logic [W-1:0] latchOut;
  logic refreshMode;

  int checks = 0, errors = 0;
  logic [W-1:0] model [D];
  int mRow = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  line_refresh_mem u0 (
    .clk(clk), .rstN(rstN), .lineP(lineP), .shiftClk(shiftClk),
    .frameStart(frameStart), .lineData(lineData),
    .latchOut(latchOut), .refreshMode(refreshMode)
  );

  // vector: {frameStart, shift clock count[3:0], pattern select[3:0]}
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 4'd3, 4'd1},  // row0 written (R8, R4)
    {1'b0, 4'd2, 4'd2},  // row1 written
    {1'b0, 4'd0, 4'd3},  // row2 self-refresh (R6)
    {1'b0, 4'd1, 4'd4},  // row3 single clock (R7)
    {1'b1, 4'd4, 4'd5},  // row0 again, old contents seen (R3)
    {1'b0, 4'd0, 4'd6},  // row1 refresh
    {1'b0, 4'd5, 4'd7},  // row2 shows 0, refresh kept it (R6)
    {1'b0, 4'd0, 4'd8},  // row3
    {1'b1, 4'd0, 4'd9}   // row0 refresh
  };

  function automatic logic [W-1:0] pat(input int s);
    return {16'hA55A ^ 16'(s), 32'(s * 7919 + 3), 32'(~s)};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lineEvent(input logic yd, input int nclk, input logic [W-1:0] data,
                           input string tag);
    int r;
    logic [W-1:0] expLatch;
    logic expMode;
    @(negedge clk);
    lineData = data;
    for (int k = 0; k < nclk; k++) begin
      shiftClk = 1'b1; @(negedge clk);
      shiftClk = 1'b0; @(negedge clk);
    end
    lineP = 1'b1; frameStart = yd;
    @(negedge clk);
    lineP = 1'b0;            // fall sampled at next posedge
    @(negedge clk);          // latch and mode updated
    frameStart = 1'b0;
    lineData = ~data;        // must not matter after the event
    @(negedge clk);          // commit done
    r = yd ? 0 : mRow;
    expLatch = model[r];
    expMode = (nclk == 0);
    if (nclk > 0) model[r] = data;
    mRow = (r == D - 1) ? 0 : r + 1;
    check({tag, " latch"}, latchOut, expLatch);
    check({tag, " mode"}, {79'b0, refreshMode}, {79'b0, expMode});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset latch", latchOut, '0);
    check("R1 reset mode", {79'b0, refreshMode}, '0);

    // R2 R3 R4 R6 R7 R8 table walk
    for (int v = 0; v < NV; v++)
      lineEvent(VEC[v][8], int'(VEC[v][7:4]), pat(int'(VEC[v][3:0])), "R2 vector");

    // R9: shift clocks and data changes between events leave outputs alone
    begin
      logic [W-1:0] held;
      logic heldMode;
      held = latchOut; heldMode = refreshMode;
      for (int k = 0; k < 6; k++) begin
        lineData = pat(100 + k);
        shiftClk = ~shiftClk; @(negedge clk);
      end
      shiftClk = 1'b0; @(negedge clk);
      check("R9 latch hold", latchOut, held);
      check("R9 mode hold", {79'b0, refreshMode}, {79'b0, heldMode});
    end

    // R4 R5: write a full frame, starting at row 0
    for (int i = 0; i < D; i++)
      lineEvent(i == 0, 1, pat(1000 + i), "R4 frame write");
    // R5 R6: full refresh frame reading every row back; no frame start
    for (int i = 0; i < D; i++)
      lineEvent(1'b0, 0, pat(5000 + i), "R5 refresh frame");
    // R5: position wrapped from 199 to 0
    lineEvent(1'b0, 2, pat(7000), "R5 wrap");
    check("R5 wrap row0 content", latchOut, pat(1000));
    // R8 mid-frame reset after wrap progression
    lineEvent(1'b0, 0, pat(7001), "R8 pre");
    lineEvent(1'b1, 0, pat(7002), "R8 frame start");
    check("R8 row0 readback", latchOut, pat(7000));
    lineEvent(1'b0, 0, pat(7003), "R8 next row1");
    check("R8 row1 readback", latchOut, pat(1001));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule